// File: doc/BRIEF.md
# PHY Bring-Up Sequencer

This block brings an Ethernet transceiver out of power-on into a known link mode without software help. A pulse on `start` launches a fixed chain of management-bus accesses, and each access is handed to an external MDIO master over a request/acknowledge handshake. The chain runs in this order: a soft-reset write to the transceiver's control register, a poll of that register until the reset bit clears, two reads that build the 32-bit identifier, a write of the selected link-mode word, and a final read of a status register.

The sequencer compares the identifier with the `EXPECT_ID` parameter. It also bounds the reset poll by `POLL_MAX` reads. Either failure ends the run early with its own error flag. On success, the status word read last is presented on `status`. In every case `done` marks the terminal state, and it stays high until the next `start`.

Top module: `phy_bringup_seq`

## Requirements
- R1: Every request carries PHY address 0 on `mdio_phy`.
- R2: A `start` pulse seen while idle or done begins a run. The first access of a run is a write of 0x8000 to register 0.
- R3: `mdio_req` stays high, with `mdio_wr`, `mdio_reg` and `mdio_wdata` stable, until a one-cycle `mdio_ack`. Read data is taken from `mdio_rdata` in the acknowledge cycle.
- R4: After the reset write, register 0 is read repeatedly while bit 15 of the read data is 1. When bit 15 is 0, register 2 is read and then register 3.
- R5: If `POLL_MAX` reads of register 0 all return bit 15 set, the run ends with `tmo_err` = 1 and makes no further access.
- R6: The identifier is {register 2 data, register 3 data}. If it differs from `EXPECT_ID`, the run ends with `id_err` = 1 and no mode write is made.
- R7: After a good identifier, register 0 is written with a mode word that depends on `mode_sel`, sampled at `start`. The encoding is: 0 or 3 gives 0x1200 (autonegotiation), 1 gives 0x2100 (100 Mb/s full duplex), and 2 gives 0x0100 (10 Mb/s full duplex).
- R8: The last access reads register `STAT_REG` (17 by default). Its data appears on `status` when the run completes with both error flags at 0.
- R9: `done` is high in the terminal state on both success and error, and it holds until the next run starts. When either error flag is set, `status` reads 0. A new run clears both error flags.
- R10: A `start` pulse during a run has no effect on that run.
- R11: In reset, `done`, `mdio_req`, `id_err`, `tmo_err` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| mode_sel | input | 2 | Link mode selection |
| mdio_req | output | 1 | Access request to MDIO master |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | 5 | PHY address (always 0) |
| mdio_reg | output | 5 | Register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion from the master |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |
| done | output | 1 | Terminal state reached |
| id_err | output | 1 | Identifier mismatch |
| tmo_err | output | 1 | Reset poll limit reached |
| status | output | 16 | Final status word (valid on success) |

## Verification
The poll-limit edge is the hardest case to reach from the ports. The transceiver must keep the reset bit set for exactly one read fewer than the limit, and then for exactly the limit. The bench's behavioural transceiver model therefore holds bit 15 set for a programmed number of reads. With the limit overridden to 4, runs with 3 and 4 busy reads land on either side of the timeout. A `start` pulse placed in the middle of a long poll checks that a run cannot be restarted. A change of `mode_sel` right after launch checks that the mode is sampled only at `start`.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_POLL, S_IDH, S_IDL, S_MODE, S_STAT, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    LM_AUTO = 2'd0, LM_100FD = 2'd1, LM_10FD = 2'd2, LM_AUTO2 = 2'd3
  } link_mode_t;

  localparam logic [4:0]  REG_CTRL  = 5'd0;
  localparam logic [4:0]  REG_ID_HI = 5'd2;
  localparam logic [4:0]  REG_ID_LO = 5'd3;
  localparam logic [15:0] CTRL_SRST = 16'h8000;

  function automatic logic [15:0] mode_word(input link_mode_t m);
    case (m)
      LM_100FD: mode_word = 16'h2100;
      LM_10FD:  mode_word = 16'h0100;
      default:  mode_word = 16'h1200;
    endcase
  endfunction

endpackage

// File: rtl/phy_seq_rst_sync.sv
module phy_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh[STAGES-1];
endmodule

// File: rtl/phy_seq_poll_ctr.sv
module phy_seq_poll_ctr #(
  parameter int POLL_MAX = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(POLL_MAX + 1);
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign last = (cnt == CW'(POLL_MAX - 1));
endmodule

// File: rtl/phy_seq_id_chk.sv
module phy_seq_id_chk #(
  parameter logic [31:0] EXPECT_ID = 32'h0243_8C20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_hi,
  input  logic [15:0] rdata,
  output logic        id_ok
);
  logic [15:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= rdata;
  end

  assign id_ok = ({hi_q, rdata} == EXPECT_ID);
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       ack,
  input  logic       rd_busy,
  input  logic       poll_last,
  input  logic       id_ok,
  output seq_state_t state
);
  seq_state_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      S_IDLE, S_DONE: if (launch) state_d = S_RST;
      S_RST:  if (ack) state_d = S_POLL;
      S_POLL: if (ack) begin
                if (!rd_busy)      state_d = S_IDH;
                else if (poll_last) state_d = S_DONE;
              end
      S_IDH:  if (ack) state_d = S_IDL;
      S_IDL:  if (ack) state_d = id_ok ? S_MODE : S_DONE;
      S_MODE: if (ack) state_d = S_STAT;
      S_STAT: if (ack) state_d = S_DONE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter logic [31:0] EXPECT_ID = 32'h0243_8C20,
  parameter int          POLL_MAX  = 1000,
  parameter logic [4:0]  STAT_REG  = 5'd17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode_sel,
  output logic        mdio_req,
  output logic        mdio_wr,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  output logic [15:0] mdio_wdata,
  input  logic        mdio_ack,
  input  logic [15:0] mdio_rdata,
  output logic        done,
  output logic        id_err,
  output logic        tmo_err,
  output logic [15:0] status
);
  seq_state_t state;
  link_mode_t mode_q;
  logic       rst_n_i;
  logic       launch, poll_last, id_ok;
  logic       poll_busy_ack, tmo_hit, id_bad, stat_ld;

  phy_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign launch        = start & ((state == S_IDLE) | (state == S_DONE));
  assign poll_busy_ack = (state == S_POLL) & mdio_ack & mdio_rdata[15];
  assign tmo_hit       = poll_busy_ack & poll_last;
  assign id_bad        = (state == S_IDL) & mdio_ack & ~id_ok;
  assign stat_ld       = (state == S_STAT) & mdio_ack;

  phy_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i), .launch(launch), .ack(mdio_ack),
    .rd_busy(mdio_rdata[15]), .poll_last(poll_last), .id_ok(id_ok),
    .state(state)
  );

  phy_seq_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n_i), .clr(launch), .inc(poll_busy_ack),
    .last(poll_last)
  );

  phy_seq_id_chk #(.EXPECT_ID(EXPECT_ID)) u_id (
    .clk(clk), .rst_n(rst_n_i), .cap_hi((state == S_IDH) & mdio_ack),
    .rdata(mdio_rdata), .id_ok(id_ok)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    mode_q <= LM_AUTO;
    else if (launch) mode_q <= link_mode_t'(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tmo_err <= 1'b0;
      id_err  <= 1'b0;
    end else if (launch) begin
      tmo_err <= 1'b0;
      id_err  <= 1'b0;
    end else begin
      if (tmo_hit) tmo_err <= 1'b1;
      if (id_bad)  id_err  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     status <= '0;
    else if (launch)  status <= '0;
    else if (stat_ld) status <= mdio_rdata;
  end

  always_comb begin
    mdio_req   = 1'b1;
    mdio_wr    = 1'b0;
    mdio_phy   = 5'd0;
    mdio_reg   = REG_CTRL;
    mdio_wdata = '0;
    case (state)
      S_RST:  begin mdio_wr = 1'b1; mdio_wdata = CTRL_SRST; end
      S_POLL: mdio_reg = REG_CTRL;
      S_IDH:  mdio_reg = REG_ID_HI;
      S_IDL:  mdio_reg = REG_ID_LO;
      S_MODE: begin mdio_wr = 1'b1; mdio_wdata = mode_word(mode_q); end
      S_STAT: mdio_reg = STAT_REG;
      default: mdio_req = 1'b0;
    endcase
  end

  assign done = (state == S_DONE);
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_req,
  input logic        mdio_wr,
  input logic [4:0]  mdio_phy,
  input logic [4:0]  mdio_reg,
  input logic [15:0] mdio_wdata,
  input logic        mdio_ack,
  input logic        done,
  input logic        id_err,
  input logic        tmo_err,
  input logic [15:0] status
);
  a_r1_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> (mdio_phy == 5'd0));

  a_r2_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_req) |-> (mdio_wr && mdio_reg == 5'd0 && mdio_wdata == 16'h8000));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=>
      (mdio_req && $stable(mdio_wr) && $stable(mdio_reg) && $stable(mdio_wdata)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_req);

  a_r9_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (id_err || tmo_err) |-> done);

  a_r9_status_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (id_err || tmo_err) |-> (status == 16'h0000));

  a_r5_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_err && tmo_err));
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
  .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
  .mdio_ack(mdio_ack), .done(done), .id_err(id_err), .tmo_err(tmo_err),
  .status(status)
);

// File: tb/phy_bringup_seq_bench.sv
module phy_bringup_seq_bench;
  localparam logic [31:0] XID = 32'h1234_5678;
  localparam int          PMAX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic mdio_req, mdio_wr, mdio_ack, done, id_err, tmo_err;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata, status;

  always #2 clk = ~clk;

  phy_bringup_seq #(.EXPECT_ID(XID), .POLL_MAX(PMAX), .STAT_REG(5'd17)) u_phy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack),
    .mdio_rdata(mdio_rdata), .done(done), .id_err(id_err),
    .tmo_err(tmo_err), .status(status)
  );

  // behavioural transceiver + log
  logic        log_clr = 1'b0;
  logic [15:0] cfg_hi = '0, cfg_lo = '0, cfg_stat = '0;
  int          cfg_busy = 0;
  int          busy_left, n_poll, n_srst, n_mode, n_bad_addr, n_stat;
  logic        hi_seen, order_bad;
  logic [15:0] mode_seen;
  logic [1:0]  wcnt;

  always @(posedge clk) begin
    mdio_ack <= 1'b0;
    if (!rst_n || log_clr) begin
      wcnt <= 2'd0; n_poll <= 0; n_srst <= 0; n_mode <= 0; n_bad_addr <= 0;
      n_stat <= 0; hi_seen <= 1'b0; order_bad <= 1'b0; mode_seen <= 16'h0;
      busy_left <= 0; mdio_rdata <= 16'h0;
    end else if (mdio_req && !mdio_ack) begin
      if (wcnt != 2'd2) wcnt <= wcnt + 2'd1;
      else begin
        wcnt <= 2'd0;
        mdio_ack <= 1'b1;
        if (mdio_phy != 5'd0) n_bad_addr <= n_bad_addr + 1;
        if (mdio_wr) begin
          if (mdio_reg == 5'd0 && mdio_wdata == 16'h8000) begin
            n_srst <= n_srst + 1; busy_left <= cfg_busy;
          end else if (mdio_reg == 5'd0) begin
            n_mode <= n_mode + 1; mode_seen <= mdio_wdata;
          end
        end else begin
          case (mdio_reg)
            5'd0: begin
              n_poll <= n_poll + 1;
              mdio_rdata <= (busy_left > 0) ? 16'h8000 : 16'h0000;
              if (busy_left > 0) busy_left <= busy_left - 1;
            end
            5'd2: begin mdio_rdata <= cfg_hi; hi_seen <= 1'b1; end
            5'd3: begin mdio_rdata <= cfg_lo; if (!hi_seen) order_bad <= 1'b1; end
            5'd17: begin mdio_rdata <= cfg_stat; n_stat <= n_stat + 1; end
            default: mdio_rdata <= 16'hDEAD;
          endcase
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch_run(input logic [1:0] m, input logic [15:0] hi, input logic [15:0] lo,
                            input int busy, input logic [15:0] st);
    @(negedge clk);
    cfg_hi = hi; cfg_lo = lo; cfg_busy = busy; cfg_stat = st; mode_sel = m; log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [7:0]  busy;
    logic [15:0] stat;
    logic        e_id;
    logic        e_tmo;
    logic [15:0] e_mode;
    logic [7:0]  e_polls;
    logic [15:0] e_stat;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 16'h1234, 16'h5678, 8'd0,   16'h782D, 1'b0, 1'b0, 16'h1200, 8'd1, 16'h782D},
    '{2'd1, 16'h1234, 16'h5678, 8'd2,   16'h1111, 1'b0, 1'b0, 16'h2100, 8'd3, 16'h1111},
    '{2'd2, 16'h1234, 16'h5678, 8'd3,   16'h0005, 1'b0, 1'b0, 16'h0100, 8'd4, 16'h0005},
    '{2'd3, 16'h1234, 16'h5678, 8'd1,   16'hA5A5, 1'b0, 1'b0, 16'h1200, 8'd2, 16'hA5A5},
    '{2'd1, 16'h1234, 16'h5678, 8'd4,   16'hFFFF, 1'b0, 1'b1, 16'h0000, 8'd4, 16'h0000},
    '{2'd0, 16'h1235, 16'h5678, 8'd0,   16'hFFFF, 1'b1, 1'b0, 16'h0000, 8'd1, 16'h0000},
    '{2'd2, 16'h1234, 16'h5679, 8'd200, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 8'd4, 16'h0000},
    '{2'd2, 16'h1234, 16'h5679, 8'd0,   16'hFFFF, 1'b1, 1'b0, 16'h0000, 8'd1, 16'h0000}
  };

  task automatic finish_bench;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_bench();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0);
    chk("R11 req", mdio_req, 0);
    chk("R11 errs", {id_err, tmo_err}, 0);
    chk("R11 status", status, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    foreach (VEC[i]) begin
      launch_run(VEC[i].mode, VEC[i].hi, VEC[i].lo, int'(VEC[i].busy), VEC[i].stat);
      wait_done();
      chk("R9 done", done, 1);
      chk("R6 id_err", id_err, VEC[i].e_id);
      chk("R5 tmo_err", tmo_err, VEC[i].e_tmo);
      chk("R8 R3 status", status, VEC[i].e_stat);          // captured on ack
      chk("R7 mode word", mode_seen, VEC[i].e_mode);
      chk("R7 R6 mode writes", n_mode, (VEC[i].e_mode != 0) ? 1 : 0);
      chk("R4 R5 polls", n_poll, VEC[i].e_polls);
      chk("R4 id order", order_bad, 0);
      chk("R2 reset write", n_srst, 1);
      chk("R1 addr", n_bad_addr, 0);
      repeat (5) @(negedge clk);
      chk("R9 done held", done, 1);
      chk("R5 R9 no access after end", mdio_req, 0);
    end

    // R7 mode sampled at start only
    launch_run(2'd1, 16'h1234, 16'h5678, 0, 16'h0042);
    mode_sel = 2'd2;
    wait_done();
    chk("R7 mode latched", mode_seen, 16'h2100);
    chk("R9 errors cleared on new run", {id_err, tmo_err}, 0);
    chk("R8 status", status, 16'h0042);

    // R10 start during a run
    launch_run(2'd0, 16'h1234, 16'h5678, 3, 16'h0777);
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R10 single reset write", n_srst, 1);
    chk("R10 poll count", n_poll, 4);
    chk("R10 status", status, 16'h0777);

    // R11 reset in mid-run
    launch_run(2'd0, 16'h1234, 16'h5678, 200, 16'h0001);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid req", mdio_req, 0);
    chk("R11 mid done", done, 0);
    chk("R11 mid status", status, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 idle after reset", {mdio_req, done}, 0);

    finish_bench();
  end
endmodule